// File: doc/BRIEF.md
# Double-Buffered Synthesizer Divider Programming Port

This block loads divider settings for a frequency synthesizer. A word of settings is assembled in a primary holding register from one of two entry paths. The first is a serial bit stream clocked by its own strobe line. The second is an 8-bit parallel bus that writes one byte lane at a time. A transfer strobe copies the assembled word into a secondary register. The secondary register is the active word: it feeds the main-divider, swallow-counter and reference-divider fields. This lets a new setting be built without disturbing the counters until the whole word is ready.

A parallel write to the top address goes to an 8-bit control register. Its bits request power-down of the synthesizer core and select which internal signal appears on the debug output. Other bits disable the divided-clock outputs, or switch to immediate mode, in which the active word follows the holding register on every cycle. The three low bits of the control register are reserved. A write that sets any of them still takes effect, and a sticky error flag is raised.

Top module: `synth_prog_if`

## Requirements
- R1: After a synchronous reset, the active word, the holding register, every control output and the error flag are all zero.
- R2: When mode_par is 0, each rising edge of ser_clk shifts ser_data into bit 0 of the holding register, and the older bits move one place towards the MSB. A 20-bit word is therefore sent MSB first.
- R3: When mode_par is 1, a par_wr pulse with par_addr 0 loads holding bits 7:0. Address 1 loads bits 15:8. Address 2 loads bits 19:16 from par_data[3:0], and par_data[7:4] is ignored for this address.
- R4: A cycle with load high copies the holding register into the active word at that clock edge. Without load and without immediate mode, the active word holds its value.
- R5: cnt_m is act_word[6:0], cnt_a is act_word[10:7] and cnt_r is act_word[14:11].
- R6: When mode_par is 1, ser_clk edges are ignored. When mode_par is 0, par_wr pulses are ignored, and that includes writes to the control register.
- R7: A parallel write to par_addr 3 loads the control register. Bit 3 drives pwr_down, bit 4 drives imm_load and bit 7 drives clk_out_dis. All control bits are active high.
- R8: While imm_load is 1, the active word takes the holding register's value on every cycle with no load pulse. It therefore shows a new holding value one cycle after that value was written.
- R9: dbg_sel is 2'b01 (modulus select) when control bit 5 is set and 2'b10 (raw prescaler) when only bit 6 is set. If both bits are set, bit 5 wins. It is 2'b00 when neither bit is set.
- R10: A control write with any of bits 2:0 set still updates the other control outputs and sets rsv_err. rsv_err then stays 1 until reset, including through later writes that set no reserved bit.
- R11: With pwr_down at 1, the entry paths, the load strobe and further control writes still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_par | input | 1 | 0 selects the serial path, 1 selects the parallel path |
| ser_clk | input | 1 | Serial bit strobe, sampled by clk |
| ser_data | input | 1 | Serial data bit |
| load | input | 1 | Transfer strobe, holding register to active word |
| par_wr | input | 1 | Parallel write strobe, one cycle |
| par_addr | input | 2 | Byte lane 0 to 2, or 3 for the control register |
| par_data | input | 8 | Parallel write data |
| act_word | output | 20 | Active (secondary) divider word |
| cnt_m | output | 7 | Main divider field |
| cnt_a | output | 4 | Swallow counter field |
| cnt_r | output | 4 | Reference divider field |
| pwr_down | output | 1 | Core power-down request |
| imm_load | output | 1 | Immediate and continuous transfer mode |
| dbg_sel | output | 2 | Debug output source: 00 off, 01 modulus select, 10 prescaler |
| clk_out_dis | output | 1 | Divided clock outputs disabled |
| rsv_err | output | 1 | Sticky flag: a reserved control bit was written |

## Verification
A parallel write or a load pulse shows on the ports at the clock edge that samples it. The bench drives each strobe for one cycle between falling edges and reads the result at the next falling edge. A serial bit needs two edges: one to sample ser_clk and the data, and one to shift. The bench holds ser_clk high and then low for two cycles each, so every bit is in place before the next action. In immediate mode, the bench checks the active word twice after a write: at the first falling edge it must still hold the old value, and at the second it must hold the new one.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int WORD_W   = 20;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int M_W      = 7;
  localparam int A_W      = 4;
  localparam int R_W      = 4;
  localparam int M_LSB    = 0;
  localparam int A_LSB    = M_LSB + M_W;
  localparam int R_LSB    = A_LSB + A_W;
  localparam int PD_BIT   = 3;
  localparam int IMM_BIT  = 4;
  localparam int MSEL_BIT = 5;
  localparam int PRE_BIT  = 6;
  localparam int OE_BIT   = 7;
  localparam int RSV_N    = 3;

  typedef enum logic [1:0] {
    DBG_OFF  = 2'b00,
    DBG_MSEL = 2'b01,
    DBG_PRE  = 2'b10
  } dbg_sel_t;
endpackage

// File: rtl/sip_entry.sv
module sip_entry #(
  parameter int WORD_W = sip_pkg::WORD_W,
  parameter int BYTE_W = sip_pkg::BYTE_W,
  parameter int ADDR_W = sip_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_par,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              par_wr,
  input  logic [ADDR_W-1:0] par_addr,
  input  logic [BYTE_W-1:0] par_data,
  output logic [WORD_W-1:0] primary
);
  localparam int NLANES = (WORD_W + BYTE_W - 1) / BYTE_W;

  logic sclk_q, sclk_qq, sdat_q;
  logic ser_edge;
  logic [NLANES-1:0] lane_hit;
  logic [WORD_W-1:0] par_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      sdat_q  <= 1'b0;
    end else begin
      sclk_q  <= ser_clk;
      sclk_qq <= sclk_q;
      sdat_q  <= ser_data;
    end
  end

  assign ser_edge = sclk_q & ~sclk_qq;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int LO = g * BYTE_W;
    localparam int LW = ((WORD_W - LO) < BYTE_W) ? (WORD_W - LO) : BYTE_W;
    assign lane_hit[g] = par_wr && mode_par && (par_addr == ADDR_W'(g));
    assign par_next[LO +: LW] = lane_hit[g] ? par_data[LW-1:0] : primary[LO +: LW];
    if (LW < BYTE_W) begin : g_part
      logic [BYTE_W-LW-1:0] dropped;
      assign dropped = par_data[BYTE_W-1:LW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primary <= '0;
    end else if (mode_par) begin
      primary <= par_next;
    end else if (ser_edge) begin
      primary <= {primary[WORD_W-2:0], sdat_q};
    end
  end
endmodule

// File: rtl/sip_xfer.sv
module sip_xfer #(
  parameter int WORD_W = sip_pkg::WORD_W,
  parameter int M_W    = sip_pkg::M_W,
  parameter int A_W    = sip_pkg::A_W,
  parameter int R_W    = sip_pkg::R_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              imm,
  input  logic [WORD_W-1:0] primary,
  output logic [WORD_W-1:0] secondary,
  output logic [M_W-1:0]    cnt_m,
  output logic [A_W-1:0]    cnt_a,
  output logic [R_W-1:0]    cnt_r
);
  localparam int A_LSB = M_W;
  localparam int R_LSB = M_W + A_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      secondary <= '0;
    end else if (load || imm) begin
      secondary <= primary;
    end
  end

  assign cnt_m = secondary[M_W-1:0];
  assign cnt_a = secondary[A_LSB +: A_W];
  assign cnt_r = secondary[R_LSB +: R_W];
endmodule

// File: rtl/sip_enh.sv
module sip_enh
  import sip_pkg::*;
#(
  parameter int BYTE_W = sip_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [BYTE_W-1:0] data,
  output logic              pwr_down,
  output logic              imm_load,
  output logic              clk_out_dis,
  output dbg_sel_t          dbg_sel,
  output logic              rsv_err
);
  dbg_sel_t dbg_next;

  always_comb begin
    if (data[MSEL_BIT])      dbg_next = DBG_MSEL;
    else if (data[PRE_BIT])  dbg_next = DBG_PRE;
    else                     dbg_next = DBG_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_down    <= 1'b0;
      imm_load    <= 1'b0;
      clk_out_dis <= 1'b0;
      dbg_sel     <= DBG_OFF;
      rsv_err     <= 1'b0;
    end else if (wr) begin
      pwr_down    <= data[PD_BIT];
      imm_load    <= data[IMM_BIT];
      clk_out_dis <= data[OE_BIT];
      dbg_sel     <= dbg_next;
      if (|data[RSV_N-1:0]) rsv_err <= 1'b1;
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import sip_pkg::*;
#(
  parameter int WORD_W = sip_pkg::WORD_W,
  parameter int BYTE_W = sip_pkg::BYTE_W,
  parameter int ADDR_W = sip_pkg::ADDR_W,
  parameter int M_W    = sip_pkg::M_W,
  parameter int A_W    = sip_pkg::A_W,
  parameter int R_W    = sip_pkg::R_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_par,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              load,
  input  logic              par_wr,
  input  logic [ADDR_W-1:0] par_addr,
  input  logic [BYTE_W-1:0] par_data,
  output logic [WORD_W-1:0] act_word,
  output logic [M_W-1:0]    cnt_m,
  output logic [A_W-1:0]    cnt_a,
  output logic [R_W-1:0]    cnt_r,
  output logic              pwr_down,
  output logic              imm_load,
  output logic [1:0]        dbg_sel,
  output logic              clk_out_dis,
  output logic              rsv_err
);
  localparam logic [ADDR_W-1:0] ENH_ADDR = '1;

  logic [WORD_W-1:0] primary;
  logic              enh_wr;
  dbg_sel_t          dbg_q;

  assign enh_wr = par_wr && mode_par && (par_addr == ENH_ADDR);

  sip_entry #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_entry (
    .clk(clk), .rst(rst), .mode_par(mode_par), .ser_clk(ser_clk),
    .ser_data(ser_data), .par_wr(par_wr), .par_addr(par_addr),
    .par_data(par_data), .primary(primary)
  );

  sip_xfer #(.WORD_W(WORD_W), .M_W(M_W), .A_W(A_W), .R_W(R_W)) u_xfer (
    .clk(clk), .rst(rst), .load(load), .imm(imm_load), .primary(primary),
    .secondary(act_word), .cnt_m(cnt_m), .cnt_a(cnt_a), .cnt_r(cnt_r)
  );

  sip_enh #(.BYTE_W(BYTE_W)) u_enh (
    .clk(clk), .rst(rst), .wr(enh_wr), .data(par_data),
    .pwr_down(pwr_down), .imm_load(imm_load), .clk_out_dis(clk_out_dis),
    .dbg_sel(dbg_q), .rsv_err(rsv_err)
  );

  assign dbg_sel = dbg_q;
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
  parameter int WORD_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_par,
  input logic              load,
  input logic              par_wr,
  input logic              imm_load,
  input logic [WORD_W-1:0] primary,
  input logic [WORD_W-1:0] act_word,
  input logic [1:0]        dbg_sel,
  input logic              rsv_err
);
  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !imm_load) |=> $stable(act_word));

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (act_word == $past(primary)));

  // R8
  imm_follow_chk: assert property (@(posedge clk) disable iff (rst)
    imm_load |=> (act_word == $past(primary)));

  // R6
  ser_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_par && !par_wr) |=> $stable(primary));

  // R9
  dbg_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dbg_sel));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rsv_err |=> rsv_err);
endmodule

bind synth_prog_if synth_prog_if_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .mode_par(mode_par), .load(load), .par_wr(par_wr),
  .imm_load(imm_load), .primary(primary), .act_word(act_word),
  .dbg_sel(dbg_sel), .rsv_err(rsv_err)
);

// File: tb/sim_synth_prog_if.sv
`timescale 1ns/1ps
module sim_synth_prog_if;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_par = 1'b0, ser_clk = 1'b0, ser_data = 1'b0, load = 1'b0, par_wr = 1'b0;
  logic [1:0]  par_addr = '0;
  logic [7:0]  par_data = '0;
  logic [19:0] act_word;
  logic [6:0]  cnt_m;
  logic [3:0]  cnt_a, cnt_r;
  logic        pwr_down, imm_load, clk_out_dis, rsv_err;
  logic [1:0]  dbg_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  synth_prog_if u0 (
    .clk(clk), .rst(rst), .mode_par(mode_par), .ser_clk(ser_clk),
    .ser_data(ser_data), .load(load), .par_wr(par_wr), .par_addr(par_addr),
    .par_data(par_data), .act_word(act_word), .cnt_m(cnt_m), .cnt_a(cnt_a),
    .cnt_r(cnt_r), .pwr_down(pwr_down), .imm_load(imm_load),
    .dbg_sel(dbg_sel), .clk_out_dis(clk_out_dis), .rsv_err(rsv_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); par_wr = 1'b1; par_addr = a; par_data = d;
    @(negedge clk); par_wr = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic ser_bit(input logic b);
    @(negedge clk); ser_data = b; ser_clk = 1'b1;
    @(negedge clk);
    @(negedge clk); ser_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic ser_word(input logic [19:0] w);
    for (int i = 19; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic t_reset();
    chk(act_word == 0, "R1 act_word", act_word, 0);
    chk({pwr_down, imm_load, dbg_sel, clk_out_dis, rsv_err} == 0, "R1 controls",
        {pwr_down, imm_load, dbg_sel, clk_out_dis, rsv_err}, 0);
    pulse_load();
    chk(act_word == 0, "R1 holding zero", act_word, 0);
  endtask

  task automatic t_serial();
    logic [19:0] w = 20'hA5C3E;
    mode_par = 1'b0;
    ser_word(w);
    chk(act_word == 0, "R4 held before load", act_word, 0);
    pulse_load();
    chk(act_word == w, "R2 serial word", act_word, w);
    chk(cnt_m == w[6:0], "R5 cnt_m", cnt_m, w[6:0]);
    chk(cnt_a == w[10:7], "R5 cnt_a", cnt_a, w[10:7]);
    chk(cnt_r == w[14:11], "R5 cnt_r", cnt_r, w[14:11]);
    pwrite(2'd0, 8'hFF);
    pulse_load();
    chk(act_word == w, "R6 parallel ignored in serial mode", act_word, w);
  endtask

  task automatic t_parallel();
    mode_par = 1'b1;
    pwrite(2'd0, 8'h12);
    pwrite(2'd1, 8'h34);
    pwrite(2'd2, 8'hF9);
    chk(act_word == 20'hA5C3E, "R4 held before load", act_word, 20'hA5C3E);
    pulse_load();
    chk(act_word == 20'h93412, "R3 byte lanes", act_word, 20'h93412);
    ser_bit(1'b1);
    ser_bit(1'b0);
    pulse_load();
    chk(act_word == 20'h93412, "R6 serial ignored in parallel mode", act_word, 20'h93412);
  endtask

  task automatic t_control();
    mode_par = 1'b1;
    pwrite(2'd3, 8'h88);
    chk(pwr_down && clk_out_dis && !imm_load, "R7 pd and oe bits",
        {pwr_down, imm_load, clk_out_dis}, 3'b101);
    chk(dbg_sel == 2'b00, "R9 none", dbg_sel, 2'b00);
    pwrite(2'd3, 8'h40);
    chk(dbg_sel == 2'b10, "R9 prescaler", dbg_sel, 2'b10);
    pwrite(2'd3, 8'h60);
    chk(dbg_sel == 2'b01, "R9 both set, bit5 wins", dbg_sel, 2'b01);
    pwrite(2'd3, 8'h20);
    chk(dbg_sel == 2'b01, "R9 msel", dbg_sel, 2'b01);
    chk(rsv_err == 1'b0, "R10 no error yet", rsv_err, 0);
    mode_par = 1'b0;
    pwrite(2'd3, 8'h08);
    chk(pwr_down == 1'b0 && dbg_sel == 2'b01, "R6 control ignored in serial mode",
        {pwr_down, dbg_sel}, 3'b001);
    mode_par = 1'b1;
  endtask

  task automatic t_reserved_pd();
    mode_par = 1'b1;
    pwrite(2'd3, 8'h0A);
    chk(rsv_err && pwr_down, "R10 accepted and flagged", {rsv_err, pwr_down}, 2'b11);
    pwrite(2'd3, 8'h08);
    chk(rsv_err == 1'b1, "R10 sticky", rsv_err, 1);
    pwrite(2'd0, 8'h5A);
    pulse_load();
    chk(act_word == 20'h9345A, "R11 programming while powered down", act_word, 20'h9345A);
  endtask

  task automatic t_immediate();
    mode_par = 1'b1;
    pwrite(2'd3, 8'h10);
    chk(imm_load == 1'b1, "R7 imm bit", imm_load, 1);
    pwrite(2'd1, 8'hC7);
    chk(act_word == 20'h9345A, "R8 one cycle later, old", act_word, 20'h9345A);
    @(negedge clk);
    chk(act_word == 20'h9C75A, "R8 follows without load", act_word, 20'h9C75A);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk({act_word, rsv_err, imm_load, pwr_down} == 0, "R1 reset clears",
        {act_word, rsv_err, imm_load, pwr_down}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_serial();
    t_parallel();
    t_control();
    t_reserved_pd();
    t_immediate();
    t_reset_again();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule